// File: doc/BRIEF.md
# Direct-Mapped Byte Read Cache

This block places a small direct-mapped cache between a processor read port and a slow backing memory. Each set holds exactly one line: a valid flag, a stored tag and a block of bytes. An incoming byte address is cut into three fields. The low bits select a byte within a block. The middle bits pick the set. The high bits form the tag that is compared against the line held in that set.

A request whose set holds a valid line with a matching tag is a hit. The requested byte returns one cycle after the request is accepted. Any other request is a miss. On a miss the processor port drops ready, and the block reads every byte of the missing block from backing memory, one byte per cycle in ascending offset order. The fetched block overwrites the resident line, and the requested byte is then returned.

Two saturating counters tally hits and misses. One synchronous clear input resets both counters. Geometry (address width, set bits, offset bits) and counter width are parameters; the offset field must be at least one bit wide.

Top module: `dm_read_cache`

## Requirements
- R1: With TAG_W = ADDR_W-SET_W-OFF_W, the address is split as follows: the block offset is bits [OFF_W-1:0], the set index is bits [SET_W+OFF_W-1:OFF_W], and the tag is bits [ADDR_W-1:SET_W+OFF_W]. Two addresses that differ only in the offset share one line.
- R2: After reset, every line is invalid, cpu_ready is 1, cpu_rvalid is 0 and both counters read 0.
- R3: A request accepted (cpu_req and cpu_ready high at a clock edge) whose set holds a valid line with an equal tag is a hit. In the next cycle, cpu_rvalid=1, cpu_hit=1, and cpu_rdata is the byte at the address's offset within the block.
- R4: On a miss, cpu_ready is 0 for 2^OFF_W cycles. In fill cycle k (k = 0 up to 2^OFF_W-1), mem_req=1 and mem_addr = {tag, set, k}, and mem_rdata is taken in the same cycle.
- R5: A miss response arrives 2^OFF_W+1 cycles after the accepting edge, with cpu_rvalid=1, cpu_hit=0 and cpu_rdata equal to the backing-memory byte at the requested address.
- R6: After a miss, the set holds the new block and the former block is evicted. With 4 sets and 2-byte blocks, the byte reads 0, 1, 7, 8, 0 on a cold cache give miss, hit, miss, miss, miss.
- R7: hit_cnt counts hits and miss_cnt counts misses, each at the accepting edge. Both hold at 2^CNT_W-1 once they reach it.
- R8: cnt_clr high at an edge sets both counters to 0 in the next cycle. It takes priority over an increment at the same edge.
- R9: cpu_rvalid is never high while cpu_ready is low, and every accepted request produces exactly one response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Read request |
| cpu_addr | input | ADDR_W | Byte address of the request |
| cpu_ready | output | 1 | Block can accept a request |
| cpu_rvalid | output | 1 | Response valid (one-cycle pulse) |
| cpu_hit | output | 1 | Response came from a hit |
| cpu_rdata | output | 8 | Returned byte |
| mem_req | output | 1 | Backing-memory read active |
| mem_addr | output | ADDR_W | Backing-memory byte address |
| mem_rdata | input | 8 | Backing-memory byte for mem_addr, same cycle |
| cnt_clr | input | 1 | Synchronous clear of both counters |
| hit_cnt | output | CNT_W | Saturating hit count |
| miss_cnt | output | CNT_W | Saturating miss count |

## Verification
Properties checked on every cycle:
- A looked-up hit is answered in the next cycle with the hit flag set.
- A looked-up miss drops ready.
- Fill addresses step by one inside a block.
- No response appears while ready is low.
- The counters never fall except on a clear, and a clear empties them.

Other behaviours need the bench scenarios against a model of tags and valid bits:
- The correctness of returned bytes.
- The hit/miss outcome of each access in a trace, including the eviction sequence and cold misses after reset.
- Exact miss latency.
- Counter saturation.
- The priority of a clear over a simultaneous increment.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [0:0] {
        ST_LOOKUP = 1'b0,
        ST_FILL   = 1'b1
    } dmc_state_e;

    typedef struct packed {
        logic              valid;
        logic              hit;
        logic [BYTE_W-1:0] data;
    } dmc_resp_t;

    function automatic int unsigned blk_bytes(input int unsigned off_w);
        return 32'd1 << off_w;
    endfunction

endpackage

// File: rtl/dmc_line_store.sv
module dmc_line_store
    import dmc_pkg::*;
#(
    parameter int SET_W = 2,
    parameter int OFF_W = 1,
    parameter int TAG_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [SET_W-1:0]  rd_set,
    input  logic [TAG_W-1:0]  rd_tag,
    input  logic [OFF_W-1:0]  rd_off,
    output logic              lookup_hit,
    output logic [BYTE_W-1:0] rd_byte,
    input  logic              wr_en,
    input  logic [SET_W-1:0]  wr_set,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              cm_en,
    input  logic [SET_W-1:0]  cm_set,
    input  logic [TAG_W-1:0]  cm_tag
);
    localparam int SETS = 1 << SET_W;
    localparam int BLK  = 1 << OFF_W;

    logic              line_valid [SETS];
    logic [TAG_W-1:0]  line_tag   [SETS];
    logic [BYTE_W-1:0] line_data  [SETS][BLK];
    logic [SETS-1:0]   set_match;

    // Tag compare for every set, one selected by the index.
    for (genvar s = 0; s < SETS; s++) begin : g_match
        assign set_match[s] = line_valid[s] && (line_tag[s] == rd_tag);
    end

    assign lookup_hit = set_match[rd_set];
    assign rd_byte    = line_data[rd_set][rd_off];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                line_valid[s] <= 1'b0;
                line_tag[s]   <= '0;
            end
        end else if (cm_en) begin
            line_valid[cm_set] <= 1'b1;
            line_tag[cm_set]   <= cm_tag;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_data[wr_set][wr_off] <= wr_byte;
        end
    end

endmodule

// File: rtl/dmc_refill_ctrl.sv
module dmc_refill_ctrl
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SET_W  = 2,
    parameter int OFF_W  = 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic              lookup_hit,
    input  logic [BYTE_W-1:0] rd_byte,
    input  logic [BYTE_W-1:0] mem_rdata,
    output logic              ready,
    output dmc_resp_t         resp,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              wr_en,
    output logic [SET_W-1:0]  wr_set,
    output logic [OFF_W-1:0]  wr_off,
    output logic              cm_en,
    output logic [SET_W-1:0]  cm_set,
    output logic [ADDR_W-SET_W-OFF_W-1:0] cm_tag,
    output logic              hit_evt,
    output logic              miss_evt
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;
    localparam logic [OFF_W-1:0] LAST_K = OFF_W'(blk_bytes(OFF_W) - 1);

    dmc_state_e        state;
    logic [ADDR_W-1:0] req_q;
    logic [OFF_W-1:0]  fill_k;
    logic [BYTE_W-1:0] cap_q;

    logic [OFF_W-1:0]  req_off;
    logic [SET_W-1:0]  req_set;
    logic [TAG_W-1:0]  req_tag;
    logic              accept;
    logic              at_off;
    logic              last_k;

    assign req_off = req_q[OFF_W-1:0];
    assign req_set = req_q[SET_W+OFF_W-1:OFF_W];
    assign req_tag = req_q[ADDR_W-1:SET_W+OFF_W];

    assign ready    = (state == ST_LOOKUP);
    assign accept   = ready && cpu_req;
    assign hit_evt  = accept && lookup_hit;
    assign miss_evt = accept && !lookup_hit;

    assign at_off   = (fill_k == req_off);
    assign last_k   = (fill_k == LAST_K);

    assign mem_req  = (state == ST_FILL);
    assign mem_addr = {req_tag, req_set, fill_k};
    assign wr_en    = mem_req;
    assign wr_set   = req_set;
    assign wr_off   = fill_k;
    assign cm_en    = mem_req && last_k;
    assign cm_set   = req_set;
    assign cm_tag   = req_tag;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_LOOKUP;
            req_q  <= '0;
            fill_k <= '0;
            cap_q  <= '0;
            resp   <= '0;
        end else begin
            resp.valid <= 1'b0;
            resp.hit   <= 1'b0;
            case (state)
                ST_LOOKUP: begin
                    if (accept) begin
                        req_q <= cpu_addr;
                        if (lookup_hit) begin
                            resp <= '{valid: 1'b1, hit: 1'b1, data: rd_byte};
                        end else begin
                            state  <= ST_FILL;
                            fill_k <= '0;
                        end
                    end
                end
                ST_FILL: begin
                    if (at_off) begin
                        cap_q <= mem_rdata;
                    end
                    fill_k <= fill_k + 1'b1;
                    if (last_k) begin
                        state <= ST_LOOKUP;
                        resp  <= '{valid: 1'b1, hit: 1'b0,
                                   data: at_off ? mem_rdata : cap_q};
                    end
                end
                default: state <= ST_LOOKUP;
            endcase
        end
    end

endmodule

// File: rtl/dmc_sat_counter.sv
module dmc_sat_counter #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    localparam logic [W-1:0] MAX_V = '1;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            count <= '0;
        end else if (inc && (count != MAX_V)) begin
            count <= count + 1'b1;
        end
    end

endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int SET_W  = 2,
    parameter int OFF_W  = 1,
    parameter int CNT_W  = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cpu_req,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              cpu_ready,
    output logic              cpu_rvalid,
    output logic              cpu_hit,
    output logic [7:0]        cpu_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [7:0]        mem_rdata,
    input  logic              cnt_clr,
    output logic [CNT_W-1:0]  hit_cnt,
    output logic [CNT_W-1:0]  miss_cnt
);
    localparam int TAG_W = ADDR_W - SET_W - OFF_W;

    logic              lookup_hit;
    logic [BYTE_W-1:0] rd_byte;
    logic              wr_en;
    logic [SET_W-1:0]  wr_set;
    logic [OFF_W-1:0]  wr_off;
    logic              cm_en;
    logic [SET_W-1:0]  cm_set;
    logic [TAG_W-1:0]  cm_tag;
    logic              hit_evt;
    logic              miss_evt;
    dmc_resp_t         resp;
    logic [1:0]        evt;
    logic [CNT_W-1:0]  cnt [2];

    dmc_line_store #(.SET_W(SET_W), .OFF_W(OFF_W), .TAG_W(TAG_W)) u_store (
        .clk        (clk),
        .rst        (rst),
        .rd_set     (cpu_addr[SET_W+OFF_W-1:OFF_W]),
        .rd_tag     (cpu_addr[ADDR_W-1:SET_W+OFF_W]),
        .rd_off     (cpu_addr[OFF_W-1:0]),
        .lookup_hit (lookup_hit),
        .rd_byte    (rd_byte),
        .wr_en      (wr_en),
        .wr_set     (wr_set),
        .wr_off     (wr_off),
        .wr_byte    (mem_rdata),
        .cm_en      (cm_en),
        .cm_set     (cm_set),
        .cm_tag     (cm_tag)
    );

    dmc_refill_ctrl #(.ADDR_W(ADDR_W), .SET_W(SET_W), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .cpu_req    (cpu_req),
        .cpu_addr   (cpu_addr),
        .lookup_hit (lookup_hit),
        .rd_byte    (rd_byte),
        .mem_rdata  (mem_rdata),
        .ready      (cpu_ready),
        .resp       (resp),
        .mem_req    (mem_req),
        .mem_addr   (mem_addr),
        .wr_en      (wr_en),
        .wr_set     (wr_set),
        .wr_off     (wr_off),
        .cm_en      (cm_en),
        .cm_set     (cm_set),
        .cm_tag     (cm_tag),
        .hit_evt    (hit_evt),
        .miss_evt   (miss_evt)
    );

    assign evt = {miss_evt, hit_evt};

    for (genvar i = 0; i < 2; i++) begin : g_cnt
        dmc_sat_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst   (rst),
            .clr   (cnt_clr),
            .inc   (evt[i]),
            .count (cnt[i])
        );
    end

    assign hit_cnt    = cnt[0];
    assign miss_cnt   = cnt[1];
    assign cpu_rvalid = resp.valid;
    assign cpu_hit    = resp.hit;
    assign cpu_rdata  = resp.data;

endmodule

// File: rtl/dm_read_cache_chk.sv
module dm_read_cache_chk #(
    parameter int ADDR_W = 6,
    parameter int CNT_W  = 4
) (
    input logic              clk,
    input logic              rst,
    input logic              cpu_req,
    input logic              cpu_ready,
    input logic              cpu_rvalid,
    input logic              cpu_hit,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              cnt_clr,
    input logic [CNT_W-1:0]  hit_cnt,
    input logic [CNT_W-1:0]  miss_cnt,
    input logic              lookup_hit
);

    assert_reset_state_R2: assert property (@(posedge clk)
        rst |=> (cpu_ready && !cpu_rvalid && hit_cnt == '0 && miss_cnt == '0));

    assert_hit_response_R3: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready && lookup_hit) |=> (cpu_rvalid && cpu_hit));

    assert_hit_flag_R3: assert property (@(posedge clk) disable iff (rst)
        cpu_hit |-> cpu_rvalid);

    assert_miss_stall_R4: assert property (@(posedge clk) disable iff (rst)
        (cpu_req && cpu_ready && !lookup_hit) |=> (!cpu_ready && mem_req));

    assert_fill_step_R4: assert property (@(posedge clk) disable iff (rst)
        (mem_req && $past(mem_req)) |-> (mem_addr == ADDR_W'($past(mem_addr) + 1'b1)));

    assert_no_resp_stalled_R9: assert property (@(posedge clk) disable iff (rst)
        !cpu_ready |-> !cpu_rvalid);

    assert_hit_cnt_mono_R7: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (hit_cnt >= $past(hit_cnt)));

    assert_miss_cnt_mono_R7: assert property (@(posedge clk) disable iff (rst)
        !cnt_clr |=> (miss_cnt >= $past(miss_cnt)));

    assert_clear_R8: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |=> (hit_cnt == '0 && miss_cnt == '0));

endmodule

bind dm_read_cache dm_read_cache_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .cpu_req    (cpu_req),
    .cpu_ready  (cpu_ready),
    .cpu_rvalid (cpu_rvalid),
    .cpu_hit    (cpu_hit),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .cnt_clr    (cnt_clr),
    .hit_cnt    (hit_cnt),
    .miss_cnt   (miss_cnt),
    .lookup_hit (lookup_hit)
);

// File: tb/test_dm_read_cache.sv
`timescale 1ns/1ps
module test_dm_read_cache;
    localparam int AW = 6;
    localparam int SW = 2;
    localparam int OW = 1;
    localparam int CW = 4;
    localparam int TW = AW - SW - OW;
    localparam int NS = 1 << SW;
    localparam int NB = 1 << OW;
    localparam int CMAX = (1 << CW) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          cpu_req = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic          cpu_ready, cpu_rvalid, cpu_hit;
    logic [7:0]    cpu_rdata;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic [7:0]    mem_rdata;
    logic          cnt_clr = 1'b0;
    logic [CW-1:0] hit_cnt, miss_cnt;

    int checks = 0;
    int errors = 0;

    bit            mv [NS];
    logic [TW-1:0] mt [NS];
    int            exp_h = 0;
    int            exp_m = 0;

    always #4 clk = ~clk;

    dm_read_cache #(.ADDR_W(AW), .SET_W(SW), .OFF_W(OW), .CNT_W(CW)) i_dm_read_cache (
        .clk(clk), .rst(rst), .cpu_req(cpu_req), .cpu_addr(cpu_addr),
        .cpu_ready(cpu_ready), .cpu_rvalid(cpu_rvalid), .cpu_hit(cpu_hit),
        .cpu_rdata(cpu_rdata), .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .cnt_clr(cnt_clr), .hit_cnt(hit_cnt),
        .miss_cnt(miss_cnt)
    );

    function automatic logic [7:0] mem_byte(input logic [AW-1:0] a);
        return 8'(({2'b00, a} * 8'd29) + 8'd7) ^ 8'h5A;
    endfunction

    always_comb mem_rdata = mem_byte(mem_addr);

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // One read; exp_dir: 1 hit, 0 miss, -1 take the model's prediction only.
    task automatic access(input logic [AW-1:0] a, input int exp_dir, input bit clr);
        logic [SW-1:0] s;
        logic [TW-1:0] t;
        bit            pred;
        bit            mem_ok;
        int            lat;
        s = a[SW+OW-1:OW];
        t = a[AW-1:SW+OW];
        pred = mv[s] && (mt[s] == t);
        mem_ok = 1'b1;
        @(negedge clk);
        cpu_req  = 1'b1;
        cpu_addr = a;
        cnt_clr  = clr;
        @(negedge clk);
        cpu_req = 1'b0;
        cnt_clr = 1'b0;
        lat = 1;
        while (!cpu_rvalid && lat < 40) begin
            if (!mem_req || mem_addr != {a[AW-1:OW], OW'(lat - 1)}) mem_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        if (exp_dir >= 0)
            check(cpu_hit == exp_dir[0], "R6 trace outcome", int'(cpu_hit), exp_dir);
        check(cpu_hit == pred, pred ? "R3 hit flag" : "R5 miss flag", int'(cpu_hit), int'(pred));
        check(cpu_rdata == mem_byte(a), pred ? "R3 hit data" : "R5 miss data",
              int'(cpu_rdata), int'(mem_byte(a)));
        check(lat == (pred ? 1 : NB + 1), pred ? "R3 hit latency" : "R5 miss latency",
              lat, pred ? 1 : NB + 1);
        if (!pred)
            check(mem_ok, "R4 fill address order", int'(mem_ok), 1);
        mv[s] = 1'b1;
        mt[s] = t;
        if (clr) begin
            exp_h = 0;
            exp_m = 0;
        end else if (pred) begin
            exp_h = (exp_h < CMAX) ? exp_h + 1 : CMAX;
        end else begin
            exp_m = (exp_m < CMAX) ? exp_m + 1 : CMAX;
        end
    endtask

    task automatic check_counts(input string tag);
        check(int'(hit_cnt) == exp_h, {tag, " hit count"}, int'(hit_cnt), exp_h);
        check(int'(miss_cnt) == exp_m, {tag, " miss count"}, int'(miss_cnt), exp_m);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R9 watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed_val;
        for (int i = 0; i < NS; i++) begin
            mv[i] = 1'b0;
            mt[i] = '0;
        end
        seed_val = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R2: state right after reset
        check(cpu_ready == 1'b1, "R2 ready after reset", int'(cpu_ready), 1);
        check(cpu_rvalid == 1'b0, "R2 no response after reset", int'(cpu_rvalid), 0);
        check_counts("R2");

        // R6: cold trace 0,1,7,8,0 -> miss,hit,miss,miss,miss (R1 offset sharing at 1)
        access(6'd0, 0, 1'b0);
        access(6'd1, 1, 1'b0);
        access(6'd7, 0, 1'b0);
        access(6'd8, 0, 1'b0);
        access(6'd0, 0, 1'b0);
        check_counts("R7 after trace");

        // R1: address 9 shares block with 8 only if tag/set match; 8 was evicted by 0
        access(6'd9, 0, 1'b0);
        access(6'd8, 1, 1'b0);

        // Random mix, biased toward a small window for hits
        for (int i = 0; i < 80; i++) begin
            logic [AW-1:0] a;
            if ($urandom_range(0, 1) == 0) a = AW'($urandom_range(0, 11));
            else a = AW'($urandom_range(0, (1 << AW) - 1));
            access(a, -1, 1'b0);
        end
        check_counts("R7 after random");

        // R8: plain clear
        @(negedge clk);
        cnt_clr = 1'b1;
        @(negedge clk);
        cnt_clr = 1'b0;
        exp_h = 0;
        exp_m = 0;
        check_counts("R8 clear");

        // R8: clear at the same edge as an accepted request wins
        access(6'd63, -1, 1'b1);
        check_counts("R8 clear priority");

        // R7: saturation on hits
        for (int i = 0; i < CMAX + 6; i++) access(6'd63, 1, 1'b0);
        check(int'(hit_cnt) == CMAX, "R7 hit saturation", int'(hit_cnt), CMAX);
        check_counts("R7 final");

        // R9: idle after all traffic
        @(negedge clk);
        check(cpu_ready == 1'b1 && cpu_rvalid == 1'b0, "R9 idle state",
              int'({cpu_ready, cpu_rvalid}), 2);
        finish_run();
    end

endmodule